// File: doc/BRIEF.md
# Integer Exception Flag Register

This block holds a 32-bit status word that records the results of integer arithmetic. It keeps three flags: a sticky summary overflow, an overflow and a carry. It also holds a 7-bit byte count that string transfers use. Each cycle an operation-class code arrives with the two top carries of a 32-bit add or subtract, or the sign and lost-bit information of an arithmetic right shift. The block then updates the flags that the class may touch and leaves the rest alone.

Software can write the whole word through a write port and read it back on `xer_q`. Bits are numbered big-endian: bit 0 is vector index 31. The flags are at bits 0 to 2 (indices 31 to 29). Bits 16 to 23 (indices 15:8) are a reserved byte that keeps whatever software writes. The byte count is at bits 25 to 31 (indices 6:0). Every other reserved position reads as zero. All state is held in registers with a synchronous active-high reset, and each change shows on the outputs one clock after the stimulus.

Top module: `int_exc_reg`

## Requirements
- R1: After a synchronous reset, `xer_q` is 0x00000000 and all three flag outputs are 0.
- R2: Summary overflow (index 31) is sticky. Once set, it stays set until a software write clears it. It is set in the cycle after any operation that sets the overflow flag.
- R3: When `op_cls` is 2'b01 or 2'b10 and `ov_en` is 1, overflow (index 30) is loaded with `c_msb ^ c_sub`, so it is cleared when the two carries are equal. When `ov_en` is 0, overflow and summary overflow are unchanged.
- R4: When `op_cls` is 2'b10 (carrying or extended add/subtract), carry (index 29) is loaded with `c_msb`. When `op_cls` is 2'b01, carry is unchanged.
- R5: When `op_cls` is 2'b11 (arithmetic right shift), carry is loaded with `sra_neg & sra_lost`. Overflow and summary overflow are unchanged.
- R6: When `op_cls` is 2'b00 (compare or other non-carrying operation), all three flags are unchanged.
- R7: A software write stores `sw_wdata[6:0]` as the byte count (bits 25 to 31). It reads back on `xer_q[6:0]` and on `byte_cnt`, and no operation changes it.
- R8: A software write stores `sw_wdata[15:8]` (reserved bits 16 to 23). It reads back unchanged, and no operation changes it.
- R9: `xer_q[28:16]` and `xer_q[7]` (reserved bits 3 to 15 and 24) always read 0, whatever is written.
- R10: When `sw_we` is 1, the next value of every stored field comes from `sw_wdata`, even if an operation that would change the flags arrives in the same cycle.
- R11: `so_q`, `ov_q` and `ca_q` always equal `xer_q[31]`, `xer_q[30]` and `xer_q[29]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_cls | input | 2 | Operation class: 00 hold, 01 add/sub, 10 carrying add/sub, 11 arithmetic right shift |
| ov_en | input | 1 | Overflow-enable bit of the operation |
| c_msb | input | 1 | Carry out of the most significant bit (bit 0) |
| c_sub | input | 1 | Carry out of the next bit (bit 1), i.e. into the MSB |
| sra_neg | input | 1 | Shift source is negative |
| sra_lost | input | 1 | At least one 1 bit was shifted out |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| xer_q | output | 32 | Register read-back value |
| so_q | output | 1 | Summary overflow flag |
| ov_q | output | 1 | Overflow flag |
| ca_q | output | 1 | Carry flag |
| byte_cnt | output | 7 | Byte-count field |

## Verification
A wrong flag-update choice shows up on `xer_q` and the flag outputs at the sampling point one clock after the operation. A lost sticky bit also shows on every later cycle until software rewrites the word. Errors in the kept byte or the byte count persist across all following operations, so a full-word comparison after each cycle exposes them on the next sample. Overflow is driven in both signed directions (positive plus positive, and negative plus negative). This separates a correct XOR of the two carries from a check of the MSB carry alone.

// File: rtl/ixr_pkg.sv
package ixr_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 7;
  localparam int KEEP_W = 8;
  localparam int FLAG_W = 3;
  localparam int GAP_W  = 1;
  localparam int ZHI_W  = WORD_W - FLAG_W - KEEP_W - GAP_W - CNT_W;

  localparam int SO_IX   = WORD_W - 1;
  localparam int OV_IX   = WORD_W - 2;
  localparam int CA_IX   = WORD_W - 3;
  localparam int KEEP_LO = CNT_W + GAP_W;

  typedef enum logic [1:0] {
    OPC_HOLD  = 2'b00,
    OPC_ADD   = 2'b01,
    OPC_ADDC  = 2'b10,
    OPC_SHRA  = 2'b11
  } op_cls_e;

  typedef struct packed {
    logic so;
    logic ov;
    logic ca;
  } flags_t;
endpackage

// File: rtl/ixr_flag_next.sv
module ixr_flag_next
  import ixr_pkg::*;
(
  input  logic [1:0] op_cls,
  input  logic       ov_en,
  input  logic       c_msb,
  input  logic       c_sub,
  input  logic       sra_neg,
  input  logic       sra_lost,
  input  flags_t     cur,
  output flags_t     nxt
);
  logic arith;
  logic ovf;

  always_comb begin
    arith = (op_cls == OPC_ADD) || (op_cls == OPC_ADDC);
    ovf   = c_msb ^ c_sub;
    nxt   = cur;
    if (arith && ov_en) begin
      nxt.ov = ovf;
      nxt.so = cur.so | ovf;
    end
    case (op_cls)
      OPC_ADDC: nxt.ca = c_msb;
      OPC_SHRA: nxt.ca = sra_neg & sra_lost;
      default:  nxt.ca = cur.ca;
    endcase
  end
endmodule

// File: rtl/ixr_sw_fields.sv
module ixr_sw_fields #(
  parameter int CNT_W  = 7,
  parameter int KEEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CNT_W-1:0]  cnt_d,
  input  logic [KEEP_W-1:0] keep_d,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [KEEP_W-1:0] keep_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      keep_q <= '0;
    end else if (we) begin
      cnt_q  <= cnt_d;
      keep_q <= keep_d;
    end
  end

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(cnt_q) && $stable(keep_q))); // R8
endmodule

// File: rtl/int_exc_reg.sv
module int_exc_reg
  import ixr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_cls,
  input  logic              ov_en,
  input  logic              c_msb,
  input  logic              c_sub,
  input  logic              sra_neg,
  input  logic              sra_lost,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_wdata,
  output logic [WORD_W-1:0] xer_q,
  output logic              so_q,
  output logic              ov_q,
  output logic              ca_q,
  output logic [CNT_W-1:0]  byte_cnt
);
  flags_t flg_q, flg_n, flg_calc;
  logic [KEEP_W-1:0] keep_q;

  ixr_flag_next u_next (
    .op_cls   (op_cls),
    .ov_en    (ov_en),
    .c_msb    (c_msb),
    .c_sub    (c_sub),
    .sra_neg  (sra_neg),
    .sra_lost (sra_lost),
    .cur      (flg_q),
    .nxt      (flg_calc)
  );

  always_comb begin
    if (sw_we) flg_n = '{so: sw_wdata[SO_IX], ov: sw_wdata[OV_IX], ca: sw_wdata[CA_IX]};
    else       flg_n = flg_calc;
  end

  always_ff @(posedge clk) begin
    if (rst) flg_q <= '0;
    else     flg_q <= flg_n;
  end

  ixr_sw_fields #(.CNT_W(CNT_W), .KEEP_W(KEEP_W)) u_fields (
    .clk    (clk),
    .rst    (rst),
    .we     (sw_we),
    .cnt_d  (sw_wdata[CNT_W-1:0]),
    .keep_d (sw_wdata[KEEP_LO +: KEEP_W]),
    .cnt_q  (byte_cnt),
    .keep_q (keep_q)
  );

  assign xer_q = {flg_q.so, flg_q.ov, flg_q.ca, {ZHI_W{1'b0}}, keep_q, {GAP_W{1'b0}}, byte_cnt};
  assign so_q  = flg_q.so;
  assign ov_q  = flg_q.ov;
  assign ca_q  = flg_q.ca;

  AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (so_q && !sw_we) |=> so_q); // R2
  AST_OV_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && ov_en && (op_cls == OPC_ADD || op_cls == OPC_ADDC)) |=> (ov_q == $past(c_msb ^ c_sub))); // R3
  AST_CA_CARRYING: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && op_cls == OPC_ADDC) |=> (ca_q == $past(c_msb))); // R4
  AST_CA_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && op_cls == OPC_SHRA) |=> (ca_q == $past(sra_neg && sra_lost) && $stable(ov_q) && $stable(so_q))); // R5
  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && op_cls == OPC_HOLD) |=> ($stable(so_q) && $stable(ov_q) && $stable(ca_q))); // R6
  AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (xer_q[SO_IX] == $past(sw_wdata[SO_IX]) && xer_q[CA_IX] == $past(sw_wdata[CA_IX])
               && byte_cnt == $past(sw_wdata[CNT_W-1:0]))); // R10
endmodule

// File: tb/sim_int_exc_reg.sv
module sim_int_exc_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] op_cls = 2'b00;
  logic ov_en = 1'b0, c_msb = 1'b0, c_sub = 1'b0, sra_neg = 1'b0, sra_lost = 1'b0;
  logic sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] xer_q;
  logic so_q, ov_q, ca_q;
  logic [6:0] byte_cnt;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] mdl = '0;

  always #10 clk = ~clk;

  int_exc_reg u0 (
    .clk(clk), .rst(rst), .op_cls(op_cls), .ov_en(ov_en), .c_msb(c_msb), .c_sub(c_sub),
    .sra_neg(sra_neg), .sra_lost(sra_lost), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .xer_q(xer_q), .so_q(so_q), .ov_q(ov_q), .ca_q(ca_q), .byte_cnt(byte_cnt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] model_next(logic [31:0] cur, logic [1:0] op, logic oe,
                                              logic c0, logic c1, logic ng, logic ls,
                                              logic we, logic [31:0] wd);
    logic [31:0] r;
    r = cur;
    if (we) return wd & 32'hE000_FF7F;
    if ((op == 2'b01 || op == 2'b10) && oe) begin
      r[30] = c0 ^ c1;
      r[31] = cur[31] | (c0 ^ c1);
    end
    if (op == 2'b10) r[29] = c0;
    if (op == 2'b11) r[29] = ng & ls;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run = n_run + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] op, logic oe, logic c0, logic c1, logic ng, logic ls,
                      logic we, logic [31:0] wd);
    op_cls = op; ov_en = oe; c_msb = c0; c_sub = c1; sra_neg = ng; sra_lost = ls;
    sw_we = we; sw_wdata = wd;
    mdl = model_next(mdl, op, oe, c0, c1, ng, ls, we, wd);
    @(negedge clk);
    sw_we = 1'b0; op_cls = 2'b00;
  endtask

  task automatic add_op(logic [31:0] a, logic [31:0] b, logic cin, logic [1:0] op, logic oe);
    logic [32:0] s;
    logic [31:0] l;
    s = {1'b0, a} + {1'b0, b} + {32'd0, cin};
    l = {1'b0, a[30:0]} + {1'b0, b[30:0]} + {31'd0, cin};
    step(op, oe, s[32], l[31], 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic full_chk(string req);
    chk(req, xer_q, mdl);
    chk("R9", {19'd0, xer_q[28:16], xer_q[7]} , 32'd0);
    chk("R11", {29'd0, so_q, ov_q, ca_q}, {29'd0, xer_q[31:29]});
    chk("R7", {25'd0, byte_cnt}, {25'd0, xer_q[6:0]});
  endtask

  initial begin
    logic [31:0] ra, rb, wd;
    logic [1:0] op;
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    mdl = '0;
    @(negedge clk);
    full_chk("R1");

    // R3 positive overflow: 7FFFFFFF + 1
    add_op(32'h7FFF_FFFF, 32'h1, 1'b0, 2'b01, 1'b1); full_chk("R3");
    chk("R2", {31'd0, so_q}, 32'd1);
    // R3 no overflow clears OV, SO remains (R2)
    add_op(32'h1, 32'h1, 1'b0, 2'b01, 1'b1); full_chk("R2");
    // R3 negative overflow: 80000000 + 80000000, carrying so CA set (R4)
    add_op(32'h8000_0000, 32'h8000_0000, 1'b0, 2'b10, 1'b1); full_chk("R4");
    // R3 with ov_en low: OV unchanged
    add_op(32'h0000_0001, 32'h0000_0001, 1'b0, 2'b01, 1'b0); full_chk("R3");
    // R4 plain add leaves CA
    add_op(32'hFFFF_FFFF, 32'h1, 1'b0, 2'b01, 1'b0); full_chk("R4");
    // R5 shift cases
    step(2'b11, 1'b0, 0, 0, 1'b1, 1'b1, 1'b0, '0); full_chk("R5");
    step(2'b11, 1'b1, 0, 0, 1'b1, 1'b0, 1'b0, '0); full_chk("R5");
    step(2'b11, 1'b0, 0, 0, 1'b0, 1'b1, 1'b0, '0); full_chk("R5");
    // R6 hold class with carries present
    step(2'b00, 1'b1, 1, 0, 1'b1, 1'b1, 1'b0, '0); full_chk("R6");
    // R8/R9 write all ones
    step(2'b00, 1'b0, 0, 0, 0, 0, 1'b1, 32'hFFFF_FFFF); full_chk("R8");
    chk("R8", {24'd0, xer_q[15:8]}, 32'h0000_00FF);
    chk("R7", {25'd0, byte_cnt}, 32'h7F);
    // R10 write clears flags while op would set them
    step(2'b10, 1'b1, 1, 0, 0, 0, 1'b1, 32'h0000_5A25); full_chk("R10");
    chk("R10", xer_q, 32'h0000_5A25);
    // R8 operations leave kept byte
    add_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 2'b10, 1'b1); full_chk("R8");

    for (int i = 0; i < 3000; i++) begin
      ra = $urandom; rb = $urandom; op = 2'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        wd = $urandom;
        step(op, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1, wd);
        full_chk("R10");
      end else if (op == 2'b11) begin
        step(op, 1'($urandom), 0, 0, ra[31], |rb[3:0], 1'b0, '0);
        full_chk("R5");
      end else if (op == 2'b00) begin
        step(op, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, '0);
        full_chk("R6");
      end else begin
        add_op(ra, rb, 1'($urandom), op, 1'($urandom));
        full_chk("R3");
      end
    end

    // R1 reset again
    rst = 1'b1; mdl = '0;
    @(negedge clk); rst = 1'b0;
    full_chk("R1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule